// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Sequencer

This block sits on the host side of an asynchronous parallel flash device. It turns a one-word request interface (valid, address, data, ready) into a write cycle on the flash bus in which the write-enable strobe sets the timing. It drives chip enable, write enable, output enable, the address lines and a bidirectional data bus. Each minimum interval of the bus cycle is given as a parameter in nanoseconds. Each is converted into a whole number of system clock cycles by ceiling division, and a result of zero becomes one cycle. The low width of write enable, its high width, the data setup to its rising edge, the address hold after its falling edge and the cycle-to-cycle period are therefore all met by counting.

The block also applies two start-up guards before any write can begin. The power-good input must be high continuously for the supply settling time. The flash reset pin, which the block observes but does not drive, must have been high continuously for the reset recovery time. A request is accepted only when the sequencer is idle and both guards are satisfied. Reads and status polling are handled elsewhere, so output enable is held inactive.

Top module: `flashWriteSeq`

## Requirements
- R1: While rstN is low and after it is released, the strobes ceN, weN and oeN are all high (inactive) and reqReady is low until the start-up guards of R2 and R3 are met.
- R2: reqReady cannot be high until powerGood has been sampled high on VCS = max(1, ceil(T_VCS_NS/CLK_PERIOD_NS)) consecutive rising clock edges. Any cycle with powerGood low restarts the count. With defaults VCS = 2500, so reqReady is first seen high VCS cycles after powerGood rises.
- R3: reqReady cannot be high until flashRstN has been sampled high on RSP = max(1, ceil(T_RSP_NS/CLK_PERIOD_NS)) consecutive edges. Any low cycle restarts the count. With defaults RSP = 200.
- R4: A request is accepted at a rising edge where reqValid and reqReady are both high. In the very next cycle ceN and weN are low together, flashAddr equals the accepted address and flashData carries the accepted data.
- R5: weN stays low for exactly LOW = max(cyc(T_WP_NS), cyc(T_DS_NS), cyc(T_AH_NS)) cycles, where cyc(t) = max(1, ceil(t/CLK_PERIOD_NS)). With defaults LOW = 3.
- R6: flashData holds the accepted word for the whole low phase, so setup to the weN rise is at least LOW cycles. flashAddr changes only in the cycle weN falls and holds until the next accepted request.
- R7: ceN rises in the same cycle as weN, and both stay high until the next accepted request.
- R8: reqReady stays low from acceptance until the cycle has lasted TOTAL = max(cyc(T_WC_NS), LOW + cyc(T_WPH_NS), LOW + 2) cycles. Back-to-back requests therefore produce weN falling edges exactly TOTAL cycles apart (6 with defaults), with weN high for at least cyc(T_WPH_NS) cycles between them.
- R9: oeN is high at all times.
- R10: reqValid, reqAddr and reqData are ignored while reqReady is low. No write starts, and flashAddr and the strobes are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset of the sequencer |
| powerGood | input | 1 | High while the flash supply is within range |
| flashRstN | input | 1 | Observed level of the flash reset pin |
| reqValid | input | 1 | Host write request present |
| reqReady | output | 1 | Sequencer can accept a request this cycle |
| reqAddr | input | ADDR_W | Word address of the request |
| reqData | input | DATA_W | Data word of the request |
| ceN | output | 1 | Flash chip enable, active low |
| weN | output | 1 | Flash write enable, active low |
| oeN | output | 1 | Flash output enable, active low (held high) |
| flashAddr | output | ADDR_W | Flash address lines |
| flashData | inout | DATA_W | Flash data bus, driven only during the write-enable low phase |

## Verification
The assertions take for granted that powerGood and flashRstN change only between clock edges. They also assume that the host holds a request stable for the edge at which it is accepted, and that after rstN the bus has not yet seen a write-enable edge, so the first fall is exempt from the gap checks. The bench drives every input at the falling clock edge. It raises the guard inputs only after reset and releases reqValid one cycle before the sequencer returns to idle. During a busy cycle it sprays random valid, address and data values, which R10 requires to have no effect.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;

  // Strobes from the sequencing control to the bus datapath.
  typedef struct packed {
    logic load;       // capture request address and data
    logic busLow;     // write phase: chip enable and write enable asserted
    logic driveData;  // enable the data bus output drivers
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } seqState_t;

  // Nanoseconds to clock cycles, rounded up, never below one.
  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 2,
  parameter int VCS_CYC  = 2500,
  parameter int RSP_CYC  = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerGood,
  input  logic       flashRstN,
  input  logic       reqValid,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  localparam int PHASE_MAX = maxOf(LOW_CYC, HIGH_CYC);
  localparam int PW = $clog2(PHASE_MAX + 1);
  localparam int VW = $clog2(VCS_CYC + 1);
  localparam int RW = $clog2(RSP_CYC + 1);

  seqState_t     state;
  logic [PW-1:0] phaseCnt;
  logic [VW-1:0] vcsCnt;
  logic [RW-1:0] rspCnt;
  logic          vcsDone;
  logic          rspDone;
  logic          accept;

  assign vcsDone  = (vcsCnt == VW'(VCS_CYC));
  assign rspDone  = (rspCnt == RW'(RSP_CYC));
  assign reqReady = (state == ST_IDLE) && vcsDone && rspDone;
  assign accept   = reqReady && reqValid;

  always_comb begin
    strobe           = '0;
    strobe.load      = accept;
    strobe.busLow    = (state == ST_LOW);
    strobe.driveData = (state == ST_LOW);
  end

  // Start-up guards: consecutive high samples, saturating.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vcsCnt <= '0;
      rspCnt <= '0;
    end else begin
      if (!powerGood)    vcsCnt <= '0;
      else if (!vcsDone) vcsCnt <= vcsCnt + 1'b1;
      if (!flashRstN)    rspCnt <= '0;
      else if (!rspDone) rspCnt <= rspCnt + 1'b1;
    end
  end

  // Phase sequencing.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_LOW;
          phaseCnt <= PW'(1);
        end
        ST_LOW: if (phaseCnt == PW'(LOW_CYC)) begin
          state    <= ST_HIGH;
          phaseCnt <= PW'(1);
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
        ST_HIGH: if (phaseCnt == PW'(HIGH_CYC)) begin
          state    <= ST_IDLE;
          phaseCnt <= '0;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // A write phase only begins once both guards had completed.
  assert_guards_met_R2_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.busLow) |-> ($past(vcsCnt) == VW'(VCS_CYC) && $past(rspCnt) == RW'(RSP_CYC)));

  // A power drop removes readiness on the following cycle (R2).
  assert_power_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> !reqReady);

  // A reset-pin low removes readiness on the following cycle (R3).
  assert_reset_pin_R3: assert property (@(posedge clk) disable iff (!rstN)
    !flashRstN |=> !reqReady);

endmodule

// File: rtl/flashSeqDatapath.sv
module flashSeqDatapath
  import flashSeqPkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int MIN_WP  = 3,
  parameter int MIN_WPH = 2,
  parameter int MIN_DS  = 3,
  parameter int MIN_WC  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              ceN,
  output logic              weN,
  output logic              oeN,
  output logic [ADDR_W-1:0] flashAddr,
  inout  wire  [DATA_W-1:0] flashData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else if (strobe.load) begin
      addrReg <= reqAddr;
      dataReg <= reqData;
    end
  end

  assign flashAddr = addrReg;
  assign weN       = !strobe.busLow;
  assign ceN       = !strobe.busLow;
  assign oeN       = 1'b1;
  assign flashData = strobe.driveData ? dataReg : {DATA_W{1'bz}};

  // Interval counters used only by the bus-timing assertions.
  localparam int CW   = $clog2(MIN_WC + MIN_WP + MIN_WPH + MIN_DS + 4);
  localparam int CMAX = (1 << CW) - 1;

  logic [CW-1:0] lowRun;
  logic [CW-1:0] highRun;
  logic [CW-1:0] driveRun;
  logic [CW-1:0] fallGap;
  logic          weNPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun   <= '0;
      highRun  <= CW'(CMAX);
      driveRun <= '0;
      fallGap  <= CW'(CMAX);
      weNPrev  <= 1'b1;
    end else begin
      weNPrev  <= weN;
      lowRun   <= weN ? '0 : lowRun + 1'b1;
      if (!weN)                      highRun <= '0;
      else if (highRun != CW'(CMAX)) highRun <= highRun + 1'b1;
      driveRun <= strobe.driveData ? driveRun + 1'b1 : '0;
      if (weNPrev && !weN)           fallGap <= CW'(1);
      else if (fallGap != CW'(CMAX)) fallGap <= fallGap + 1'b1;
    end
  end

  assert_we_low_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> (lowRun >= CW'(MIN_WP)));

  assert_data_setup_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> (driveRun >= CW'(MIN_DS)));

  assert_addr_only_at_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(flashAddr) |-> $fell(weN));

  assert_we_high_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weN) |-> (highRun >= CW'(MIN_WPH)));

  assert_cycle_period_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weN) |-> (fallGap >= CW'(MIN_WC)));

endmodule

// File: rtl/flashWriteSeq.sv
module flashWriteSeq
  import flashSeqPkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_WC_NS       = 120,
  parameter int T_WP_NS       = 50,
  parameter int T_WPH_NS      = 30,
  parameter int T_DS_NS       = 50,
  parameter int T_AH_NS       = 50,
  parameter int T_VCS_NS      = 50000,
  parameter int T_RSP_NS      = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerGood,
  input  logic              flashRstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              ceN,
  output logic              weN,
  output logic              oeN,
  output logic [ADDR_W-1:0] flashAddr,
  inout  wire  [DATA_W-1:0] flashData
);

  localparam int WC_C     = nsToCycles(T_WC_NS, CLK_PERIOD_NS);
  localparam int WP_C     = nsToCycles(T_WP_NS, CLK_PERIOD_NS);
  localparam int WPH_C    = nsToCycles(T_WPH_NS, CLK_PERIOD_NS);
  localparam int DS_C     = nsToCycles(T_DS_NS, CLK_PERIOD_NS);
  localparam int AH_C     = nsToCycles(T_AH_NS, CLK_PERIOD_NS);
  localparam int VCS_C    = nsToCycles(T_VCS_NS, CLK_PERIOD_NS);
  localparam int RSP_C    = nsToCycles(T_RSP_NS, CLK_PERIOD_NS);
  localparam int LOW_C    = maxOf(WP_C, maxOf(DS_C, AH_C));
  // The idle cycle before the next acceptance also counts as high time.
  localparam int HIGH_TOT = maxOf(WPH_C, WC_C - LOW_C);
  localparam int HIGH_C   = (HIGH_TOT > 2) ? HIGH_TOT - 1 : 1;

  seqStrobe_t strobe;

  flashSeqCtrl #(
    .LOW_CYC (LOW_C),
    .HIGH_CYC(HIGH_C),
    .VCS_CYC (VCS_C),
    .RSP_CYC (RSP_C)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .powerGood(powerGood),
    .flashRstN(flashRstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  flashSeqDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MIN_WP (WP_C),
    .MIN_WPH(WPH_C),
    .MIN_DS (DS_C),
    .MIN_WC (WC_C)
  ) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .ceN      (ceN),
    .weN      (weN),
    .oeN      (oeN),
    .flashAddr(flashAddr),
    .flashData(flashData)
  );

  assert_accept_starts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!weN && !ceN));

  assert_busy_ignores_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable(flashAddr));

  assert_ce_follows_we_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> ceN);

endmodule

// File: tb/flashWriteSeq_test.sv
module flashWriteSeq_test;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int CLK_NS = 20;
  localparam int T_WC = 120, T_WP = 50, T_WPH = 30, T_DS = 50, T_AH = 50;
  localparam int T_VCS = 50000, T_RSP = 4000;

  function automatic int cyc(input int ns);
    int c;
    c = ns / CLK_NS;
    if (c * CLK_NS < ns) c = c + 1;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int expLow();
    int m;
    m = cyc(T_WP);
    if (cyc(T_DS) > m) m = cyc(T_DS);
    if (cyc(T_AH) > m) m = cyc(T_AH);
    return m;
  endfunction

  function automatic int expTotal();
    int m;
    m = cyc(T_WC);
    if (expLow() + cyc(T_WPH) > m) m = expLow() + cyc(T_WPH);
    if (expLow() + 2 > m) m = expLow() + 2;
    return m;
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerGood = 1'b0;
  logic flashRstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic ceN, weN, oeN;
  logic [ADDR_W-1:0] flashAddr;
  wire  [DATA_W-1:0] flashData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int sinceFall = 0;
  int lastGap = 0;
  int fallCount = 0;
  logic weSeen = 1'b1;

  always #10 clk = ~clk;

  flashWriteSeq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PERIOD_NS(CLK_NS),
    .T_WC_NS(T_WC), .T_WP_NS(T_WP), .T_WPH_NS(T_WPH), .T_DS_NS(T_DS),
    .T_AH_NS(T_AH), .T_VCS_NS(T_VCS), .T_RSP_NS(T_RSP)
  ) uut (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .flashRstN(flashRstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqData(reqData),
    .ceN(ceN), .weN(weN), .oeN(oeN), .flashAddr(flashAddr), .flashData(flashData)
  );

  // Falling-edge monitor of weN fall spacing.
  always @(negedge clk) begin
    cycles = cycles + 1;
    if (weSeen && !weN) begin
      lastGap   = sinceFall;
      sinceFall = 1;
      fallCount = fallCount + 1;
    end else begin
      sinceFall = sinceFall + 1;
    end
    weSeen = weN;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One write: waits for ready, then checks every cycle of the bus cycle.
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit noise);
    int low;
    int total;
    low = expLow();
    total = expTotal();
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    reqData  = d;
    for (int j = 1; j <= total; j++) begin
      @(negedge clk);
      if (j < total - 1 && noise) begin
        reqValid = 1'($urandom);
        reqAddr  = ADDR_W'($urandom);
        reqData  = DATA_W'($urandom);
      end else begin
        reqValid = 1'b0;
      end
      if (j <= low) begin
        check(weN == 1'b0, "R5 weN low in write phase", weN, 0);
        check(ceN == 1'b0, "R4 ceN low with weN", ceN, 0);
        check(flashAddr == a, "R4 address on bus", flashAddr, a);
        check(flashData === d, "R6 data held during low phase", flashData, d);
      end else begin
        check(weN == 1'b1, "R5 weN high after low phase", weN, 1);
        check(ceN == 1'b1, "R7 ceN rises with weN", ceN, 1);
        check(flashAddr == a, "R10 address kept while busy", flashAddr, a);
      end
      check(oeN == 1'b1, "R9 oeN high", oeN, 1);
      if (j < total) check(reqReady == 1'b0, "R8 ready low within cycle", reqReady, 0);
      else           check(reqReady == 1'b1, "R8 ready back after cycle", reqReady, 1);
    end
  endtask

  initial begin : watchdog
    waitNeg(150000);
    check(1'b0, "watchdog expired", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stimulus
    int n;
    process::self().srandom(32'h5eed_0042);
    void'($urandom(32'h5eed_0042));

    // R1: reset state.
    waitNeg(3);
    check(weN && ceN && oeN, "R1 strobes high in reset", {weN, ceN, oeN}, 3'b111);
    check(reqReady == 1'b0, "R1 not ready in reset", reqReady, 0);
    rstN = 1'b1;
    waitNeg(2);
    check(weN && ceN, "R1 strobes high after reset", {weN, ceN}, 2'b11);
    check(reqReady == 1'b0, "R1 not ready before guards", reqReady, 0);

    // R2 with R3 together; requests during the guard are ignored (R10).
    powerGood = 1'b1;
    flashRstN = 1'b1;
    reqValid  = 1'b1;
    reqAddr   = 20'h1_2345;
    n = cyc(T_VCS);
    if (cyc(T_RSP) > n) n = cyc(T_RSP);
    waitNeg(n - 1);
    check(reqReady == 1'b0, "R2 ready held until power guard ends", reqReady, 0);
    check(fallCount == 0, "R10 no write during guard", fallCount, 0);
    check(flashAddr == '0, "R10 address untouched during guard", flashAddr, 0);
    reqValid = 1'b0;
    waitNeg(1);
    check(reqReady == 1'b1, "R2 ready once power guard ends", reqReady, 1);

    // R3: reset pin pulse restarts its recovery count.
    flashRstN = 1'b0;
    waitNeg(5);
    check(reqReady == 1'b0, "R3 not ready with reset pin low", reqReady, 0);
    flashRstN = 1'b1;
    waitNeg(cyc(T_RSP) - 1);
    check(reqReady == 1'b0, "R3 ready held during recovery", reqReady, 0);
    waitNeg(1);
    check(reqReady == 1'b1, "R3 ready after recovery", reqReady, 1);

    // R2: a supply dip restarts the power guard.
    powerGood = 1'b0;
    waitNeg(2);
    powerGood = 1'b1;
    waitNeg(cyc(T_VCS) - 1);
    check(reqReady == 1'b0, "R2 dip restarts guard", reqReady, 0);
    waitNeg(1);
    check(reqReady == 1'b1, "R2 ready after restarted guard", reqReady, 1);

    // Directed writes, corner values, back to back.
    doWrite('0, 8'h00, 1'b0);
    doWrite('1, 8'hFF, 1'b0);
    check(lastGap == expTotal(), "R8 back-to-back fall spacing", lastGap, expTotal());
    doWrite(20'hA_5A5A, 8'h5A, 1'b1);
    check(lastGap == expTotal(), "R8 spacing with busy noise", lastGap, expTotal());

    // Random writes with random idle gaps and busy-time noise.
    for (int k = 0; k < 40; k++) begin
      int gap;
      int gapSeen;
      gap = int'($urandom_range(0, 3));
      waitNeg(gap);
      doWrite(ADDR_W'($urandom), DATA_W'($urandom), 1'b1);
      gapSeen = lastGap;
      if (k > 0) check(gapSeen >= expTotal(), "R8 fall spacing at least cycle time", gapSeen, expTotal());
    end

    waitNeg(4);
    check(weN && ceN && oeN, "R7 strobes idle at end", {weN, ceN, oeN}, 3'b111);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule